// File: doc/BRIEF.md
# Inter-computer message sender

This block is the initiating half of a controller that sits on a bus shared by several computers. The local processor supplies two words: a routing header, which is the receiver number times 4096 plus the sender number, and an address/command word. It then pulses a send strobe. The block captures both words and asks the bus arbiter for mastership. Once granted, it drives the header and then the address word, one bus cycle each. It then waits a bounded time for the addressed node to return one reply word.

When the reply arrives, or the wait expires, the block stores the reply word and a status word. It drops its bus request and pulses a completion interrupt to the processor, whatever the outcome was. Only one transfer can be in flight at a time. The arbiter is seen as a plain request/grant pair.

The controller steps through six named states:

| State | What happens | Leaves to |
|---|---|---|
| `ST_IDLE` | Waits for a send. | `ST_REQ`, on accept when `send_i` is high. |
| `ST_REQ` | Holds the bus request. | `ST_HDR`, on grant when `bus_gnt_i` is high. |
| `ST_HDR` | Drives the header. | `ST_ADR`, unconditionally. |
| `ST_ADR` | Drives the address word. | `ST_WAIT`, unconditionally. |
| `ST_WAIT` | Waits for the reply. | `ST_DONE`, on a reply or on expiry. |
| `ST_DONE` | Pulses the interrupt. | `ST_IDLE`, unconditionally. |

Top module: `hms_sender`

## Requirements
- R1: After reset, `busy_o`, `irq_o`, `bus_req_o` and `bus_wvalid_o` are 0, and `rx_data_o` and `status_o` are 0.
- R2: A `send_i` pulse seen in idle captures `hdr_i` and `addr_i`. From the next cycle, `busy_o` and `bus_req_o` are 1, and status and reply data read 0.
- R3: Nothing is driven on the bus (`bus_wvalid_o` = 0) until `bus_gnt_i` is seen. In the cycle after the grant, the captured header is driven with `bus_wvalid_o` = 1.
- R4: In the cycle after the header, the captured address word is driven with bit 23 (the most significant bit) forced to 1, which marks a hardware message.
- R5: A reply (`bus_rvalid_i`) is taken in any of the first TMO_CYC cycles after the address cycle. Its word is stored in `rx_data_o`.
- R6: If no reply arrives in those TMO_CYC cycles, status bit 21 (timeout) is set and `rx_data_o` is 0.
- R7: Parity is even over the 24 data bits: `bus_rpar_i` must equal the XOR of `bus_rdata_i`. A mismatch on the accepted reply sets status bit 22.
- R8: A reply strobe during the header or address cycle sets status bit 23 (overrun). The block then keeps waiting for the real reply.
- R9: `irq_o` is a one-cycle pulse in the cycle after the reply or expiry. In that cycle `bus_req_o` is 0 and `busy_o` is still 1. `busy_o` is 0 in the cycle after.
- R10: A `send_i` pulse while `busy_o` is 1 is ignored. It changes neither the words sent nor the timing, and no new request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| send_i | input | 1 | Send strobe from the processor |
| hdr_i | input | 24 | Routing header (receiver*4096 + sender) |
| addr_i | input | 24 | Address/command word |
| busy_o | output | 1 | Transfer in progress |
| irq_o | output | 1 | Completion interrupt pulse |
| rx_data_o | output | 24 | Reply word received |
| status_o | output | 24 | Bit 23 overrun, bit 22 parity, bit 21 timeout |
| bus_req_o | output | 1 | Bus mastership request |
| bus_gnt_i | input | 1 | Bus grant from arbiter |
| bus_wvalid_o | output | 1 | Word driven on bus this cycle |
| bus_wdata_o | output | 24 | Word driven on bus |
| bus_rvalid_i | input | 1 | Reply word valid |
| bus_rdata_i | input | 24 | Reply word |
| bus_rpar_i | input | 1 | Parity bit of reply word |

## Verification
A controller stuck in the wrong state shows at the bus pins within one cycle. A missing or doubled word shows in `bus_wvalid_o`, a request held past completion shows in `bus_req_o`, and an interrupt arriving one cycle early or late shows in `irq_o`. A reply timer that is off by one shows only at the window boundary. There it either takes a reply in the last allowed cycle as a timeout, or lets the wait run one cycle long. The sweep therefore puts the reply at every delay up to and past the limit. A wrong flag update shows in `status_o` at the interrupt cycle, for each mix of early strobe, bad parity and expiry.

// File: rtl/hms_pkg.sv
package hms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_HDR,
        ST_ADR,
        ST_WAIT,
        ST_DONE
    } hms_state_t;
endpackage

// File: rtl/hms_reply_timer.sv
module hms_reply_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (run_i && !last_o)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/hms_parity_chk.sv
module hms_parity_chk #(
    parameter int W = 24
) (
    input  logic [W-1:0] data_i,
    input  logic         par_i,
    output logic         err_o
);
    assign err_o = (^data_i) != par_i;
endmodule

// File: rtl/hms_sender.sv
module hms_sender
    import hms_pkg::*;
#(
    parameter int DW      = 24,
    parameter int TMO_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          send_i,
    input  logic [DW-1:0] hdr_i,
    input  logic [DW-1:0] addr_i,
    output logic          busy_o,
    output logic          irq_o,
    output logic [DW-1:0] rx_data_o,
    output logic [DW-1:0] status_o,
    output logic          bus_req_o,
    input  logic          bus_gnt_i,
    output logic          bus_wvalid_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic          bus_rvalid_i,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_rpar_i
);
    localparam int BIT_OVR = DW - 1;
    localparam int BIT_PAR = DW - 2;
    localparam int BIT_TMO = DW - 3;
    localparam logic [DW-1:0] HMSG_MARK = {1'b1, {(DW-1){1'b0}}};

    hms_state_t    state_q, state_d;
    logic [DW-1:0] hdr_q, adr_q, rx_q, sts_q;
    logic          tmo_last, par_err, accept;

    hms_reply_timer #(.LIMIT(TMO_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q != ST_WAIT),
        .run_i  (state_q == ST_WAIT),
        .last_o (tmo_last)
    );

    hms_parity_chk #(.W(DW)) u_par (
        .data_i (bus_rdata_i),
        .par_i  (bus_rpar_i),
        .err_o  (par_err)
    );

    assign accept = (state_q == ST_IDLE) && send_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (send_i)    state_d = ST_REQ;
            ST_REQ:  if (bus_gnt_i) state_d = ST_HDR;
            ST_HDR:                 state_d = ST_ADR;
            ST_ADR:                 state_d = ST_WAIT;
            ST_WAIT: if (bus_rvalid_i || tmo_last) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
            adr_q <= '0;
            rx_q  <= '0;
            sts_q <= '0;
        end else if (accept) begin
            hdr_q <= hdr_i;
            adr_q <= addr_i;
            rx_q  <= '0;
            sts_q <= '0;
        end else if ((state_q == ST_HDR || state_q == ST_ADR) && bus_rvalid_i) begin
            sts_q[BIT_OVR] <= 1'b1;
        end else if (state_q == ST_WAIT) begin
            if (bus_rvalid_i) begin
                rx_q <= bus_rdata_i;
                if (par_err)
                    sts_q[BIT_PAR] <= 1'b1;
            end else if (tmo_last) begin
                sts_q[BIT_TMO] <= 1'b1;
            end
        end
    end

    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        irq_o        = 1'b0;
        bus_req_o    = 1'b0;
        bus_wvalid_o = 1'b0;
        bus_wdata_o  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  bus_req_o = 1'b1;
            ST_HDR: begin
                bus_req_o    = 1'b1;
                bus_wvalid_o = 1'b1;
                bus_wdata_o  = hdr_q;
            end
            ST_ADR: begin
                bus_req_o    = 1'b1;
                bus_wvalid_o = 1'b1;
                bus_wdata_o  = adr_q | HMSG_MARK;
            end
            ST_WAIT: bus_req_o = 1'b1;
            ST_DONE: irq_o     = 1'b1;
            default: ;
        endcase
    end

    assign rx_data_o = rx_q;
    assign status_o  = sts_q;
endmodule

// File: rtl/hms_sender_chk.sv
module hms_sender_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          send_i,
    input logic          busy_o,
    input logic          irq_o,
    input logic [DW-1:0] status_o,
    input logic          bus_req_o,
    input logic          bus_gnt_i,
    input logic          bus_wvalid_o,
    input logic [DW-1:0] bus_wdata_o
);
    // R9: interrupt is a single-cycle pulse
    a_r9_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R9: busy drops right after the interrupt
    a_r9_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !busy_o);

    // R9: request released only when the interrupt is raised
    a_r9_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req_o) |-> irq_o);

    // R10: busy holds until the interrupt, whatever the strobe does
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !irq_o) |=> busy_o);

    // R3: the bus is driven only while mastership is requested
    a_r3_drive_owned: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wvalid_o |-> bus_req_o);

    // R3: the first driven word follows a grant
    a_r3_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wvalid_o) |-> $past(bus_gnt_i));

    // R4: second consecutive word carries the hardware-message mark
    a_r4_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wvalid_o && $past(bus_wvalid_o)) |-> bus_wdata_o[DW-1]);

    // R6/R7: parity and timeout never flagged together
    a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !(status_o[DW-2] && status_o[DW-3]));

    // R2: an accepted strobe raises the request in the next cycle
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && send_i) |=> bus_req_o);
endmodule

bind hms_sender hms_sender_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .send_i       (send_i),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .status_o     (status_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_wvalid_o (bus_wvalid_o),
    .bus_wdata_o  (bus_wdata_o)
);

// File: tb/hms_sender_tb_top.sv
module hms_sender_tb_top;
    localparam int DW  = 24;
    localparam int TMO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          send_i = 1'b0;
    logic [DW-1:0] hdr_i = '0, addr_i = '0;
    logic          busy_o, irq_o, bus_req_o, bus_wvalid_o;
    logic [DW-1:0] rx_data_o, status_o, bus_wdata_o;
    logic          bus_gnt_i = 1'b0, bus_rvalid_i = 1'b0, bus_rpar_i = 1'b0;
    logic [DW-1:0] bus_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hms_sender #(.DW(DW), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .send_i(send_i), .hdr_i(hdr_i), .addr_i(addr_i),
        .busy_o(busy_o), .irq_o(irq_o), .rx_data_o(rx_data_o), .status_o(status_o),
        .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_wvalid_o(bus_wvalid_o),
        .bus_wdata_o(bus_wdata_o), .bus_rvalid_i(bus_rvalid_i),
        .bus_rdata_i(bus_rdata_i), .bus_rpar_i(bus_rpar_i)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input int g, input int d, input bit bad, input bit early,
                           input bit ign, input int n);
        logic [DW-1:0] hdr, adr, dat, exp_sts, exp_rx;
        bit reply;
        int k;
        bit got;
        hdr   = (DW'(n % 4096) << 12) | DW'((n * 7 + 3) % 4096);
        adr   = DW'((n * 24'h01F3D5) & 24'h7FFFFF);
        dat   = DW'(24'h5A0000 ^ (n * 24'h001357));
        reply = (d <= TMO - 1);
        exp_sts = (early ? 24'h800000 : 24'h0) | ((reply && bad) ? 24'h400000 : 24'h0)
                | (!reply ? 24'h200000 : 24'h0);
        exp_rx  = reply ? dat : '0;

        @(negedge clk);
        send_i = 1'b1; hdr_i = hdr; addr_i = adr;
        @(negedge clk);
        send_i = 1'b0; hdr_i = ~hdr; addr_i = ~adr;
        chk("R2 busy", DW'(busy_o), 1);
        chk("R2 req", DW'(bus_req_o), 1);
        chk("R2 status cleared", status_o, 0);
        chk("R3 no drive before grant", DW'(bus_wvalid_o), 0);
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            chk("R3 idle bus while waiting grant", DW'(bus_wvalid_o), 0);
        end
        bus_gnt_i = 1'b1;
        @(negedge clk);
        bus_gnt_i = 1'b0;
        chk("R3 header valid", DW'(bus_wvalid_o), 1);
        chk("R3 header word", bus_wdata_o, hdr);
        if (early) begin
            bus_rvalid_i = 1'b1; bus_rdata_i = 24'hDEAD00; bus_rpar_i = 1'b0;
        end
        @(negedge clk);
        bus_rvalid_i = 1'b0;
        chk("R4 address valid", DW'(bus_wvalid_o), 1);
        chk("R4 address word", bus_wdata_o, adr | 24'h800000);
        k = 0; got = 1'b0;
        while (!got && k < TMO + 4) begin
            @(negedge clk);
            k++;
            bus_rvalid_i = 1'b0;
            send_i = 1'b0;
            if (irq_o) begin
                got = 1'b1;
            end else begin
                chk("R5 request held while waiting", DW'(bus_req_o), 1);
                if (ign && k == 1) begin
                    send_i = 1'b1; hdr_i = 24'h123456; addr_i = 24'h654321;
                end
                if (reply && k == d + 1) begin
                    bus_rvalid_i = 1'b1;
                    bus_rdata_i  = dat;
                    bus_rpar_i   = (^dat) ^ bad;
                end
            end
        end
        chk(reply ? "R5 irq latency after reply" : "R6 irq latency on timeout",
            DW'(k), reply ? DW'(d + 2) : DW'(TMO + 1));
        chk("R9 req dropped at irq", DW'(bus_req_o), 0);
        chk("R9 busy at irq", DW'(busy_o), 1);
        chk(reply ? "R5 reply data" : "R6 data zero on timeout", rx_data_o, exp_rx);
        chk("R6 R7 R8 status", status_o, exp_sts);
        if (ign) send_i = 1'b1;
        @(negedge clk);
        send_i = 1'b0;
        chk("R9 irq one cycle", DW'(irq_o), 0);
        chk("R9 busy cleared", DW'(busy_o), 0);
        @(negedge clk);
        chk("R10 no restart from ignored send", DW'({busy_o, bus_req_o}), 0);
    endtask

    initial begin
        #1;
        chk("R1 busy", DW'(busy_o), 0);
        chk("R1 irq", DW'(irq_o), 0);
        chk("R1 req", DW'({bus_req_o, bus_wvalid_o}), 0);
        chk("R1 rx", rx_data_o, 0);
        chk("R1 status", status_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int g = 0; g < 3; g++)
            for (int d = 0; d <= TMO + 1; d++)
                run_txn(g, d, (d % 2) == 1, d == 2, d == 1, g * 16 + d + 1);
        // R8 with a timeout, R7 at the last allowed reply cycle
        run_txn(1, TMO, 1'b0, 1'b1, 1'b1, 200);
        run_txn(0, TMO - 1, 1'b1, 1'b1, 1'b0, 201);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog act hung exp done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule